// File: doc/BRIEF.md
# Multi-channel compare-match PWM timer

A timer block with four independent 16-bit up-counting channels, configured over a simple 16-bit register bus. Each channel has its own bank of control, mode, output-control, interrupt-enable, status, counter and four general compare registers. A single shared start register gates every channel, and a halted channel holds its counter value.

Each channel drives one waveform output and one interrupt line. A compare match between the counter and a general register sets a status flag. A match on a selectable general register can clear the counter. Register A's match applies a programmable action to the output. In PWM mode the output returns to a programmed initial level whenever the counter clears, so clearing on B gives a period of B+1 counts. Writing the output-control register forces the output to its initial level at once, which is how software holds a fixed 0% or 100% level.

Writes take effect on the clock edge where `we_i` is high. Reads are combinational from `addr_i`.

Top module: `cmt_pwm_timer`

## Requirements
- R1: After reset every register reads 0, all channels are halted, and all `wave_o` and `irq_o` bits are 0.
- R2: The start register is at address 0x00. Bit n set runs channel n and bit n clear halts it. A halted channel keeps its counter value. A running channel at prescaler code 0 counts once per clock.
- R3: Control bits 1:0 select the divide ratio: codes 0 to 3 select 1, 4, 16 and 64. Control bits 4:3 select the counting edge of the divided clock: 0 rising, 1 falling, 2 both. At divide-by-1 the channel counts every clock. Otherwise, 64 running clocks give 64/N counts on one edge and 128/N counts on both edges.
- R4: Control bits 7:5 select what clears the counter: 0 none, 1 match on A, 2 match on B, 5 match on C, 6 match on D. The count that leaves the selected register's value goes to 0 instead, so the sequence is 0..G, giving G+1 counts.
- R5: A count leaving a value equal to general register A, B, C or D sets status bit 0, 1, 2 or 3 respectively. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R6: `irq_o[n]` is high while any status bit of channel n is set with its matching enable bit (same bit position) set.
- R7: Writing output control (bank offset 0x08) drives `wave_o` to the written bit 2 on the next clock, also while the channel is halted.
- R8: In normal mode (mode bits 1:0 not equal to 2), an A match applies output-control bits 1:0 to the output: 0 keep, 1 low, 2 high, 3 toggle.
- R9: In PWM mode (mode bits 1:0 = 2), each counter clear returns the output to output-control bit 2. A clear takes precedence over an A action on the same count. With clearing on B, the output holds the initial level for A+1 counts of every B+1. With A equal to B, the output stays at the initial level.
- R10: A counter write loads the value on the next clock and overrides any count in that cycle.
- R11: Mode bits 6:4 are stored and read back but do not change the waveform.
- R12: Channel n's bank starts at 0x10 + n*0x40. Within a bank the offsets are: control 0x00, mode 0x04, output control 0x08, interrupt enable 0x0C, status 0x10, counter 0x14, and general registers A to D at 0x18, 0x1C, 0x20 and 0x24. Each bank is distinct from the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data for addr_i |
| wave_o | output | 4 | Waveform output per channel |
| irq_o | output | 4 | Interrupt line per channel |

## Verification
The bench runs each prescaler and edge combination for exactly 64 clocks, so the count it expects does not depend on the prescaler phase. A wrong tap or edge detector shows up as a count off by a factor of two or four. It samples the PWM output over two whole periods. A design that let the A action win over the clear when A equals B would emit a low pulse instead of a steady level. A design with an off-by-one on the clear value would count the wrong number of highs. It also checks the following:
- the status write-one-to-clear, where an inverted mask would clear the wrong flag;
- the output-control force while halted, which a design gated on the run bit would ignore;
- a counter write in the same cycle as a count, which must win.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int unsigned CH_DW  = 16;
  localparam int unsigned NGR    = 4;
  localparam logic [7:0] ADR_START   = 8'h00;
  localparam logic [7:0] BANK_BASE   = 8'h10;
  localparam int unsigned BANK_SHIFT = 6;

  typedef enum logic [5:0] {
    OFS_CTRL = 6'h00,
    OFS_MODE = 6'h04,
    OFS_IOC  = 6'h08,
    OFS_IEN  = 6'h0C,
    OFS_STAT = 6'h10,
    OFS_CNT  = 6'h14,
    OFS_GRA  = 6'h18,
    OFS_GRB  = 6'h1C,
    OFS_GRC  = 6'h20,
    OFS_GRD  = 6'h24
  } reg_ofs_e;

  localparam logic [1:0] MODE_PWM  = 2'd2;
  localparam logic [6:0] MODE_MASK = 7'h73;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] psc_i,
  input  logic [1:0] edge_i,
  output logic       tick_o
);
  localparam int unsigned PW = 6;

  logic [PW-1:0] pre_q, pre_n;
  logic          tap_q, tap_n;

  assign pre_n = pre_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    pre_q <= '0;
    else if (run_i) pre_q <= pre_n;

  // divided clock is counter bit 2*code-1
  always_comb begin
    tap_q = 1'b0;
    tap_n = 1'b0;
    if (psc_i != 2'd0) begin
      tap_q = pre_q[{psc_i, 1'b0} - 3'd1];
      tap_n = pre_n[{psc_i, 1'b0} - 3'd1];
    end
  end

  always_comb begin
    if (!run_i)              tick_o = 1'b0;
    else if (psc_i == 2'd0)  tick_o = 1'b1;
    else unique case (edge_i)
      2'd0:    tick_o = !tap_q &&  tap_n;
      2'd1:    tick_o =  tap_q && !tap_n;
      default: tick_o =  tap_q != tap_n;
    endcase
  end

  assert_tick_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && psc_i != 2'd0) |=> (!tick_o || psc_i != $past(psc_i)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned DW = CH_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          we_i,
  input  logic [5:0]    ofs_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          wave_o,
  output logic          irq_o
);
  logic [7:0]           ctrl_q;
  logic [6:0]           mode_q;
  logic [2:0]           ioc_q;
  logic [NGR-1:0]       ien_q, stat_q, match;
  logic [DW-1:0]        cnt_q;
  logic [NGR-1:0][DW-1:0] gr_q;
  logic                 tick, clr_hit, pwm_mode;
  logic wr_ctrl, wr_mode, wr_ioc, wr_ien, wr_stat, wr_cnt;

  assign wr_ctrl = we_i && ofs_i == OFS_CTRL;
  assign wr_mode = we_i && ofs_i == OFS_MODE;
  assign wr_ioc  = we_i && ofs_i == OFS_IOC;
  assign wr_ien  = we_i && ofs_i == OFS_IEN;
  assign wr_stat = we_i && ofs_i == OFS_STAT;
  assign wr_cnt  = we_i && ofs_i == OFS_CNT;
  assign pwm_mode = mode_q[1:0] == MODE_PWM;

  tmr_tick u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .psc_i  (ctrl_q[1:0]),
    .edge_i (ctrl_q[4:3]),
    .tick_o (tick)
  );

  for (genvar g = 0; g < NGR; g++) begin : g_match
    assign match[g] = tick && cnt_q == gr_q[g];
  end

  always_comb begin
    unique case (ctrl_q[7:5])
      3'd1:    clr_hit = match[0];
      3'd2:    clr_hit = match[1];
      3'd5:    clr_hit = match[2];
      3'd6:    clr_hit = match[3];
      default: clr_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      ioc_q  <= '0;
      ien_q  <= '0;
      gr_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[7:0];
      if (wr_mode) mode_q <= wdata_i[6:0] & MODE_MASK;
      if (wr_ioc)  ioc_q  <= wdata_i[2:0];
      if (wr_ien)  ien_q  <= wdata_i[NGR-1:0];
      for (int i = 0; i < NGR; i++)
        if (we_i && ofs_i == 6'(OFS_GRA + 4*i)) gr_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wdata_i;
    else if (tick)   cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
  end

  // a new match wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~(wr_stat ? wdata_i[NGR-1:0] : '0)) | match;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  wave_o <= 1'b0;
    else if (wr_ioc)              wave_o <= wdata_i[2];
    else if (pwm_mode && clr_hit) wave_o <= ioc_q[2];
    else if (match[0]) begin
      unique case (ioc_q[1:0])
        2'd1:    wave_o <= 1'b0;
        2'd2:    wave_o <= 1'b1;
        2'd3:    wave_o <= !wave_o;
        default: wave_o <= wave_o;
      endcase
    end
  end

  assign irq_o = |(stat_q & ien_q);

  always_comb begin
    rdata_o = '0;
    unique case (ofs_i)
      OFS_CTRL: rdata_o = DW'(ctrl_q);
      OFS_MODE: rdata_o = DW'(mode_q);
      OFS_IOC:  rdata_o = DW'(ioc_q);
      OFS_IEN:  rdata_o = DW'(ien_q);
      OFS_STAT: rdata_o = DW'(stat_q);
      OFS_CNT:  rdata_o = cnt_q;
      OFS_GRA:  rdata_o = gr_q[0];
      OFS_GRB:  rdata_o = gr_q[1];
      OFS_GRC:  rdata_o = gr_q[2];
      OFS_GRD:  rdata_o = gr_q[3];
      default:  rdata_o = '0;
    endcase
  end

  assert_halt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_cnt) |=> $stable(cnt_q));
  assert_clear_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit && !wr_cnt) |=> cnt_q == '0);
  assert_flag_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match != '0) |=> (stat_q & $past(match)) == $past(match));
  assert_irq_raise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(match & ien_q)) && !wr_ien) |=> irq_o);
  assert_io_force_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ioc |=> wave_o == $past(wdata_i[2]));
  assert_pwm_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_mode && clr_hit && !wr_ioc) |=> wave_o == $past(ioc_q[2]));
endmodule

// File: rtl/cmt_pwm_timer.sv
module cmt_pwm_timer
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned N_CH = 4,
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = CH_DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [N_CH-1:0] wave_o,
  output logic [N_CH-1:0] irq_o
);
  localparam int unsigned CW = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [N_CH-1:0]          start_q;
  logic [AW-1:0]            rel;
  logic                     in_bank, wr_start;
  logic [CW-1:0]            ch_idx;
  logic [N_CH-1:0][DW-1:0]  ch_rd;

  assign in_bank  = addr_i >= AW'(BANK_BASE);
  assign rel      = addr_i - AW'(BANK_BASE);
  assign ch_idx   = rel[BANK_SHIFT +: CW];
  assign wr_start = we_i && addr_i == AW'(ADR_START);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       start_q <= '0;
    else if (wr_start) start_q <= wdata_i[N_CH-1:0];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    tmr_channel #(.DW(DW)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (start_q[c]),
      .we_i    (we_i && in_bank && ch_idx == CW'(c)),
      .ofs_i   (rel[BANK_SHIFT-1:0]),
      .wdata_i (wdata_i),
      .rdata_o (ch_rd[c]),
      .wave_o  (wave_o[c]),
      .irq_o   (irq_o[c])
    );
  end

  always_comb begin
    if (addr_i == AW'(ADR_START)) rdata_o = DW'(start_q);
    else if (in_bank)             rdata_o = ch_rd[ch_idx];
    else                          rdata_o = '0;
  end

  assert_start_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start |=> start_q == $past(wdata_i[N_CH-1:0]));
endmodule

// File: tb/sim_cmt_pwm_timer.sv
module sim_cmt_pwm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  wave, irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = !clk;

  cmt_pwm_timer u0 (
    .clk_i (clk), .rst_ni (rst_n), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .wave_o (wave), .irq_o (irq)
  );

  function automatic logic [7:0] ba(int ch, int ofs);
    return 8'(8'h10 + ch * 8'h40 + ofs);
  endfunction

  task automatic chk(string rq, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", rq, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  // start the masked channels and halt them after exactly k counting edges
  task automatic run(logic [3:0] mask, int k);
    wr(8'h00, {12'h0, mask});
    repeat (k - 1) @(posedge clk);
    wr(8'h00, 16'h0);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(8'h00, d);        chk("R1 start", d, 0);
    rd(ba(0, 0), d);     chk("R1 ctrl0", d, 0);
    rd(ba(3, 'h14), d);  chk("R1 cnt3", d, 0);
    rd(ba(2, 'h18), d);  chk("R1 gra2", d, 0);
    chk("R1 wave", wave, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_map;
    logic [15:0] d;
    wr(ba(3, 'h24), 16'hBEEF);
    rd(ba(3, 'h24), d);  chk("R12 grd3", d, 16'hBEEF);
    rd(ba(2, 'h24), d);  chk("R12 grd2 distinct", d, 0);
    wr(ba(3, 'h24), 16'h0);
  endtask

  task automatic t_count;
    logic [15:0] d;
    run(4'b0010, 10);
    rd(ba(1, 'h14), d);  chk("R2 cnt1 runs", d, 10);
    rd(ba(0, 'h14), d);  chk("R2 cnt0 halted", d, 0);
    repeat (5) @(posedge clk);
    rd(ba(1, 'h14), d);  chk("R2 cnt1 held", d, 10);
  endtask

  task automatic t_prescale;
    logic [15:0] d;
    for (int p = 0; p < 4; p++) begin
      for (int e = 0; e < 3; e++) begin
        int n, ex;
        n  = 1 << (2 * p);
        ex = (p == 0) ? 64 : ((e == 2) ? 128 / n : 64 / n);
        wr(ba(2, 'h14), 16'h0);
        wr(ba(2, 'h00), 16'((e << 3) | p));
        run(4'b0100, 64);
        rd(ba(2, 'h14), d);
        chk($sformatf("R3 psc%0d edge%0d", p, e), d, ex);
      end
    end
  endtask

  task automatic t_clear_flags;
    logic [15:0] d;
    wr(ba(0, 'h00), 16'h0040);
    wr(ba(0, 'h18), 16'd2);
    wr(ba(0, 'h1C), 16'd4);
    wr(ba(0, 'h20), 16'd9);
    wr(ba(0, 'h24), 16'd10);
    wr(ba(0, 'h10), 16'hF);
    wr(ba(0, 'h14), 16'h0);
    run(4'b0001, 12);
    rd(ba(0, 'h14), d);  chk("R4 clear on B", d, 2);
    rd(ba(0, 'h10), d);  chk("R5 flags A B", d, 16'h3);
    wr(ba(0, 'h10), 16'h1);
    rd(ba(0, 'h10), d);  chk("R5 w1c A", d, 16'h2);
    wr(ba(0, 'h10), 16'h0);
    rd(ba(0, 'h10), d);  chk("R5 w0 no effect", d, 16'h2);
    wr(ba(0, 'h0C), 16'h2);
    chk("R6 irq on B", irq[0], 1);
    wr(ba(0, 'h0C), 16'h1);
    chk("R6 irq masked", irq[0], 0);
    wr(ba(0, 'h0C), 16'h0);
    wr(ba(0, 'h00), 16'h00A0);
    wr(ba(0, 'h20), 16'd6);
    wr(ba(0, 'h14), 16'h0);
    run(4'b0001, 20);
    rd(ba(0, 'h14), d);  chk("R4 clear on C", d, 6);
    wr(ba(0, 'h00), 16'h0020);
    wr(ba(0, 'h14), 16'h0);
    run(4'b0001, 7);
    rd(ba(0, 'h14), d);  chk("R4 clear on A", d, 1);
  endtask

  task automatic t_ioforce;
    logic [15:0] d;
    wr(ba(3, 'h08), 16'h4);
    chk("R7 force high halted", wave[3], 1);
    rd(ba(3, 'h08), d);  chk("R7 readback", d, 16'h4);
    wr(ba(3, 'h08), 16'h0);
    chk("R7 force low", wave[3], 0);
  endtask

  task automatic t_normal;
    wr(ba(1, 'h18), 16'd3);
    wr(ba(1, 'h08), 16'h3);
    wr(ba(1, 'h14), 16'h0);
    run(4'b0010, 4);
    chk("R8 toggle on A", wave[1], 1);
    wr(ba(1, 'h08), 16'h5);
    wr(ba(1, 'h14), 16'h0);
    run(4'b0010, 3);
    chk("R8 before A", wave[1], 1);
    run(4'b0010, 1);
    chk("R8 drive low", wave[1], 0);
    wr(ba(1, 'h08), 16'h2);
    wr(ba(1, 'h14), 16'h0);
    run(4'b0010, 4);
    chk("R8 drive high", wave[1], 1);
  endtask

  task automatic t_pwm;
    logic [15:0] d;
    int hi;
    wr(ba(0, 'h00), 16'h0040);
    wr(ba(0, 'h04), 16'h0072);
    rd(ba(0, 'h04), d);  chk("R11 buffer bits stored", d, 16'h72);
    wr(ba(0, 'h18), 16'd1);
    wr(ba(0, 'h1C), 16'd4);
    wr(ba(0, 'h14), 16'h0);
    wr(ba(0, 'h08), 16'h5);
    wr(8'h00, 16'h1);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      hi += int'(wave[0]);
    end
    wr(8'h00, 16'h0);
    chk("R9 R11 pwm duty A1 B4", hi, 4);
    wr(ba(0, 'h18), 16'd4);
    wr(ba(0, 'h14), 16'h0);
    wr(ba(0, 'h08), 16'h5);
    wr(8'h00, 16'h1);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      hi += int'(wave[0]);
    end
    wr(8'h00, 16'h0);
    chk("R9 A equals B full", hi, 10);
  endtask

  task automatic t_cntwr;
    logic [15:0] d;
    wr(ba(3, 'h14), 16'h1234);
    rd(ba(3, 'h14), d);  chk("R10 halted load", d, 16'h1234);
    wr(8'h00, 16'h8);
    wr(ba(3, 'h14), 16'h0100);
    wr(8'h00, 16'h0);
    rd(ba(3, 'h14), d);  chk("R10 write beats count", d, 16'h0101);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog got 0 exp 1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_map();
    t_count();
    t_prescale();
    t_clear_flags();
    t_ioforce();
    t_normal();
    t_pwm();
    t_cntwr();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule